// File: doc/BRIEF.md
# Parallel Flash Programming Port Controller

This block models the parallel programming port of a small on-chip code flash. An external programmer puts an address, a data byte and a mode code on the inputs. It then pulses the active-low program strobe. When the strobe is released, the block starts the selected operation.

Byte writes and lock-bit writes time themselves with a cycle counter. During that time a ready flag is held low. A read of the byte being written returns it with its top bit inverted, so the programmer can poll for completion on the data lines as well as on the ready flag.

A programmed location cannot be programmed again until a chip erase. A chip erase needs the strobe held low for a minimum number of cycles. A signature mode returns three fixed identification bytes, and the last of them depends on the programming-voltage mode. Once both lock bits are set, verify reads no longer return the array contents. Write and erase durations, and the array depth, are parameters.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `dout` is FFh and every array location reads FFh in verify mode (mode 3'b010).
- R2: In program mode (mode 3'b001), a low-to-high transition of `prog_n` starts a byte write. `ready` is 0 from the clock edge that sees the release until WRITE_CYC clock cycles later, and then it returns to 1.
- R3: While a byte write is in progress, a verify read of the address being written returns the written byte with bit 7 inverted. After `ready` returns to 1, the same read returns the true byte.
- R4: A byte write to a location that does not hold FFh leaves that location unchanged.
- R5: In erase mode (mode 3'b011), releasing `prog_n` after fewer than ERASE_CYC low cycles has no effect on the array.
- R6: An erase strobe held low for at least ERASE_CYC cycles sets every location to FFh and clears both lock bits. Afterwards a location can be programmed again.
- R7: In signature mode (mode 3'b100), a read of address 30h returns 1Eh and a read of 31h returns 51h.
- R8: In signature mode, a read of 32h returns FFh when `hv_mode` is 1 and 05h when `hv_mode` is 0.
- R9: A lock write (mode 3'b101, self-timed like a byte write) sets lock bit one from `din[0]` and lock bit two from `din[1]`. Only when both are set do verify reads return FFh at every address.
- R10: Program, lock and erase requests that arrive while `ready` is 0 are ignored.
- R11: `dout` is registered: it reflects the mode and address inputs present at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW | Array or signature address |
| din | input | 8 | Data byte to program (lock bits in bits 1:0) |
| mode | input | 3 | Operation select |
| hv_mode | input | 1 | 1 = high-voltage programming variant |
| prog_n | input | 1 | Active-low program strobe |
| dout | output | 8 | Registered read data |
| ready | output | 1 | 1 = idle, 0 = self-timed write in progress |

## Verification
On every cycle, the embedded assertions check three things. `ready` only falls after a strobe release. Every busy period lasts exactly WRITE_CYC cycles. Signature reads and locked verify reads return their fixed values.

Other behaviour depends on a sequence of operations and can only be shown by the directed scenarios:
- refusing to rewrite a programmed byte;
- the polling inversion followed by the true data;
- the minimum erase hold time;
- erase clearing the locks;
- requests made during a busy period being discarded.

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl #(
  parameter int DEPTH     = 256,
  parameter int AW        = $clog2(DEPTH),
  parameter int WRITE_CYC = 20,
  parameter int ERASE_CYC = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic [2:0]    mode,
  input  logic          hv_mode,
  input  logic          prog_n,
  output logic [7:0]    dout,
  output logic          ready
);
  localparam int CW = $clog2(WRITE_CYC + 1);
  localparam int EW = $clog2(ERASE_CYC + 1);
  localparam logic [2:0] M_PROG = 3'b001, M_VERIFY = 3'b010, M_ERASE = 3'b011,
                         M_SIG  = 3'b100, M_LOCK   = 3'b101;

  logic [7:0]    mem [DEPTH];
  logic          prog_q, op_lock, lb1, lb2;
  logic [CW-1:0] cnt;
  logic [EW-1:0] low_cnt;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  wire release_edge = prog_n & ~prog_q;
  wire start_op = release_edge & ready & (mode == M_PROG || mode == M_LOCK);
  wire do_erase = release_edge & ready & (mode == M_ERASE) & (low_cnt >= EW'(ERASE_CYC));
  wire finish   = ~ready & (cnt == '0);
  wire locked   = lb1 & lb2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prog_q  <= 1'b1;
      low_cnt <= '0;
    end else begin
      prog_q <= prog_n;
      if (prog_n)                         low_cnt <= '0;
      else if (low_cnt != EW'(ERASE_CYC)) low_cnt <= low_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ready   <= 1'b1;
      cnt     <= '0;
      wr_addr <= '0;
      wr_data <= 8'hFF;
      op_lock <= 1'b0;
      lb1     <= 1'b0;
      lb2     <= 1'b0;
    end else begin
      if (start_op) begin
        ready   <= 1'b0;
        cnt     <= CW'(WRITE_CYC - 1);
        wr_addr <= addr;
        wr_data <= din;
        op_lock <= (mode == M_LOCK);
      end else if (finish) begin
        ready <= 1'b1;
        if (op_lock) begin
          lb1 <= lb1 | wr_data[0];
          lb2 <= lb2 | wr_data[1];
        end
      end else if (!ready) begin
        cnt <= cnt - 1'b1;
      end
      if (do_erase) begin
        lb1 <= 1'b0;
        lb2 <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (do_erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (finish && !op_lock && mem[wr_addr] == 8'hFF) begin
      mem[wr_addr] <= wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dout <= 8'hFF;
    else begin
      case (mode)
        M_VERIFY:
          if (locked)                              dout <= 8'hFF;
          else if (!ready && !op_lock && addr == wr_addr)
                                                   dout <= {~wr_data[7], wr_data[6:0]};
          else                                     dout <= mem[addr];
        M_SIG:
          if (addr == AW'('h30))      dout <= 8'h1E;
          else if (addr == AW'('h31)) dout <= 8'h51;
          else if (addr == AW'('h32)) dout <= hv_mode ? 8'hFF : 8'h05;
          else                        dout <= 8'h00;
        default: dout <= 8'hFF;
      endcase
    end

  logic [15:0] busy_len;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     busy_len <= '0;
    else if (ready) busy_len <= '0;
    else            busy_len <= busy_len + 1'b1;

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> busy_len == 16'(WRITE_CYC));

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(prog_n));

  // R7
  sig_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == M_SIG && $past(addr) == AW'('h31)) |-> dout == 8'h51);

  // R8
  sig_volt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == M_SIG && $past(addr) == AW'('h32) && !$past(hv_mode)) |-> dout == 8'h05);

  // R9
  lock_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == M_VERIFY && $past(lb1 & lb2)) |-> dout == 8'hFF);
endmodule

// File: tb/flash_prog_ctrl_bench.sv
module flash_prog_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 20;
  localparam int E = 50;

  logic       clk = 0, rst_n = 0, hv_mode = 1, prog_n = 1;
  logic [7:0] addr = 0, din = 0;
  logic [2:0] mode = 0;
  logic [7:0] dout;
  logic       ready;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_ctrl #(.DEPTH(256), .WRITE_CYC(W), .ERASE_CYC(E)) u_flash_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .mode(mode),
    .hv_mode(hv_mode), .prog_n(prog_n), .dout(dout), .ready(ready));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] m, logic [7:0] a, output logic [7:0] v);
    mode = m; addr = a;
    @(negedge clk);
    v = dout;
  endtask

  task automatic pulse(logic [2:0] m, logic [7:0] a, logic [7:0] d, int low);
    @(negedge clk);
    mode = m; addr = a; din = d; prog_n = 0;
    repeat (low) @(negedge clk);
    prog_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 1000 && !ready; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 ready", {7'd0, ready}, 8'h01);
    check("R1 dout", dout, 8'hFF);
    rd(3'b010, 8'h00, v); check("R1 loc0", v, 8'hFF);
    rd(3'b010, 8'hFF, v); check("R1 locFF", v, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] v;
    pulse(3'b001, 8'h05, 8'h3C, 2);
    check("R2 busy", {7'd0, ready}, 8'h00);
    rd(3'b010, 8'h05, v); check("R3 poll", v, 8'hBC);
    repeat (W - 2) @(negedge clk);
    check("R2 still busy", {7'd0, ready}, 8'h00);
    @(negedge clk);
    check("R2 ready", {7'd0, ready}, 8'h01);
    rd(3'b010, 8'h05, v); check("R3 true", v, 8'h3C);
    check("R11 registered", dout, 8'h3C);
  endtask

  task automatic t_no_rewrite();
    logic [7:0] v;
    pulse(3'b001, 8'h05, 8'h00, 1);
    wait_ready();
    rd(3'b010, 8'h05, v); check("R4 kept", v, 8'h3C);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v;
    pulse(3'b001, 8'h08, 8'hAA, 1);
    pulse(3'b001, 8'h09, 8'h55, 1);
    wait_ready();
    rd(3'b010, 8'h08, v); check("R10 first", v, 8'hAA);
    rd(3'b010, 8'h09, v); check("R10 ignored", v, 8'hFF);
  endtask

  task automatic t_short_erase();
    logic [7:0] v;
    pulse(3'b011, 8'h00, 8'h00, E - 1);
    rd(3'b010, 8'h05, v); check("R5 short", v, 8'h3C);
  endtask

  task automatic t_signature();
    logic [7:0] v;
    hv_mode = 1;
    rd(3'b100, 8'h30, v); check("R7 30h", v, 8'h1E);
    rd(3'b100, 8'h31, v); check("R7 31h", v, 8'h51);
    rd(3'b100, 8'h32, v); check("R8 hv", v, 8'hFF);
    hv_mode = 0;
    rd(3'b100, 8'h32, v); check("R8 lv", v, 8'h05);
    hv_mode = 1;
  endtask

  task automatic t_lock();
    logic [7:0] v;
    pulse(3'b101, 8'h00, 8'h01, 1);
    wait_ready();
    rd(3'b010, 8'h05, v); check("R9 one bit", v, 8'h3C);
    pulse(3'b101, 8'h00, 8'h02, 1);
    wait_ready();
    rd(3'b010, 8'h05, v); check("R9 locked5", v, 8'hFF);
    rd(3'b010, 8'h08, v); check("R9 locked8", v, 8'hFF);
  endtask

  task automatic t_erase();
    logic [7:0] v;
    pulse(3'b011, 8'h00, 8'h00, E);
    pulse(3'b001, 8'h05, 8'h12, 1);
    wait_ready();
    rd(3'b010, 8'h05, v); check("R6 reprogram", v, 8'h12);
    rd(3'b010, 8'h08, v); check("R6 erased", v, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_program();
    t_no_rewrite();
    t_busy_ignore();
    t_short_erase();
    t_signature();
    t_lock();
    t_erase();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule